// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the status flags of an asynchronous serial port. It sits between the transmit and receive datapaths and a simple CPU register bus. The datapaths send it single-cycle event pulses: the transmit buffer has moved into the shifter, a received word is complete (with its noise and framing qualifiers), and each receive-line sample. It also takes a level that shows the transmitter is sending. The CPU side gives read strobes for the status and data registers and a write strobe for the data register. The block returns an 8-bit status byte, the held receive word, and one interrupt request that is gated by four enable inputs.

A flag never clears on a single access. Software must first read the status register while the flag is set. This arms that flag. A later data register access then clears it: a write for the transmit flags, a read for the receive flags. A data access clears only the flags that were armed, so a flag that sets between the two accesses is kept. The idle flag comes from a counter of consecutive high samples on the receive line. The counter threshold depends on the word length. Once idle has been reported, it is not reported again until another word has been received.

All flags are registered. A strobe seen at a rising clock edge shows on `status_o` after that edge. `irq_o` is a combinational function of the flags and the enable inputs.

Top module: `sci_status_ctrl`

## Requirements
- R1: `status_o` bit positions are: 7 transmit-empty, 6 transmit-complete, 5 receive-full, 4 idle, 3 overrun, 2 noise, 1 framing error. Bit 0 always reads 0.
- R2: After reset, `status_o` is 8'hC0, `rx_data_o` is 0, and `irq_o` is 0 while all enables are low.
- R3: A `tx_load_i` pulse sets transmit-empty at the next clock edge.
- R4: Transmit-empty clears only on a `data_wr_i` that follows a `stat_rd_i` made while it was set. A data write with no such status read leaves it set.
- R5: Transmit-complete sets on any edge where transmit-empty is set and `tx_busy_i` is low. It clears through the same status-read then data-write sequence, and that clear takes priority over its set.
- R6: A `rx_done_i` pulse while receive-full is clear loads `rx_data_i` into `rx_data_o` and sets receive-full. A status read made while receive-full is set, followed by a `data_rd_i`, clears it.
- R7: A `rx_done_i` pulse while receive-full is set sets overrun and leaves `rx_data_o` unchanged. Overrun clears by a status read then a data read.
- R8: The noise and framing flags take `rx_noise_i` and `rx_frame_err_i` of the word that is loaded. Each clears by a status read then a data read.
- R9: Idle sets once the number of consecutive samples with `rx_line_i` = 1 (counted only on `rx_sample_i` cycles) reaches 10 when `word_len_i` = 0, or 11 when `word_len_i` = 1. A 0 sample restarts the count. Idle clears by a status read then a data read.
- R10: After idle has been set, it does not set again until a `rx_done_i` pulse has occurred.
- R11: A data access clears only flags that were already set at the most recent status read. A flag set after that read survives.
- R12: `irq_o` is high when any of these holds: transmit-empty with `tx_ie_i`; transmit-complete with `tc_ie_i`; receive-full or overrun with `rx_ie_i`; idle with `idle_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_load_i | input | 1 | Transmit buffer moved into shifter (pulse) |
| tx_busy_i | input | 1 | Data, preamble or break being sent |
| rx_done_i | input | 1 | Received word complete (pulse) |
| rx_data_i | input | DATA_W | Completed receive word |
| rx_noise_i | input | 1 | Completed word carried noise |
| rx_frame_err_i | input | 1 | Completed word had a framing error |
| rx_sample_i | input | 1 | Receive line sample valid |
| rx_line_i | input | 1 | Receive line sample value |
| word_len_i | input | 1 | 0: 10-bit idle threshold, 1: 11-bit |
| stat_rd_i | input | 1 | CPU reads status register |
| data_rd_i | input | 1 | CPU reads data register |
| data_wr_i | input | 1 | CPU writes data register |
| tx_ie_i | input | 1 | Transmit-empty interrupt enable |
| tc_ie_i | input | 1 | Transmit-complete interrupt enable |
| rx_ie_i | input | 1 | Receive-full / overrun interrupt enable |
| idle_ie_i | input | 1 | Idle interrupt enable |
| status_o | output | 8 | Status byte |
| rx_data_o | output | DATA_W | Receive data register |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several things on every cycle: bit 0 stays low, transmit-empty follows a load, transmit-empty and receive-full fall only after the matching data access, an overrun keeps the held word, idle rises only on a high line sample, and the interrupt never fires with all enables off. Other behaviours need ordered stimulus, and only the bench scenarios show them. These are the two-step clear, the survival of a flag set between status read and data access, the 10 and 11 sample thresholds, the counter restart on a 0 sample, and the suppression of idle until a new word arrives. The bench reference model is compared on every clock.

// File: rtl/sci_status_pkg.sv
package sci_status_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned B_TDRE   = 7;
  localparam int unsigned B_TC     = 6;
  localparam int unsigned B_RDRF   = 5;
  localparam int unsigned B_IDLE   = 4;
  localparam int unsigned B_OVR    = 3;
  localparam int unsigned B_NOISE  = 2;
  localparam int unsigned B_FRAME  = 1;

  // receive-side flag vector index
  localparam int unsigned RX_NFLAG = 5;
  localparam int unsigned RX_FULL  = 0;
  localparam int unsigned RX_IDLE  = 1;
  localparam int unsigned RX_OVR   = 2;
  localparam int unsigned RX_NOISE = 3;
  localparam int unsigned RX_FRAME = 4;

  typedef struct packed {
    logic empty;
    logic done;
  } tx_flags_t;
endpackage

// File: rtl/sci_tx_flags.sv
module sci_tx_flags
  import sci_status_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stat_rd_i,
  input  logic      data_wr_i,
  input  logic      tx_load_i,
  input  logic      tx_busy_i,
  output tx_flags_t flags_o
);
  tx_flags_t flg_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '{empty: 1'b1, done: 1'b1};
      arm_q <= '0;
    end else begin
      if (tx_load_i)                      flg_q.empty <= 1'b1;
      else if (data_wr_i && arm_q.empty)  flg_q.empty <= 1'b0;
      // clear beats set so a completed sequence is not undone
      if (data_wr_i && arm_q.done)            flg_q.done <= 1'b0;
      else if (flg_q.empty && !tx_busy_i)     flg_q.done <= 1'b1;
      if (stat_rd_i)      arm_q <= flg_q;
      else if (data_wr_i) arm_q <= '0;
    end
  end

  assign flags_o = flg_q;
endmodule

// File: rtl/sci_idle_det.sv
module sci_idle_det #(
  parameter int unsigned IDLE_SHORT = 10,
  parameter int unsigned IDLE_LONG  = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic line_i,
  input  logic word_len_i,
  input  logic word_seen_i,
  output logic hit_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_LONG + 1);
  localparam logic [CNT_W-1:0] THR_S = CNT_W'(IDLE_SHORT);
  localparam logic [CNT_W-1:0] THR_L = CNT_W'(IDLE_LONG);

  logic [CNT_W-1:0] cnt_q, thr;
  logic             armed_q;

  assign thr   = word_len_i ? THR_L : THR_S;
  assign hit_o = sample_i && line_i && armed_q && (cnt_q == thr - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (sample_i) begin
        if (!line_i)         cnt_q <= '0;
        else if (cnt_q < thr) cnt_q <= cnt_q + CNT_W'(1);
      end
      if (word_seen_i) armed_q <= 1'b1;
      else if (hit_o)  armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sci_rx_flags.sv
module sci_rx_flags
  import sci_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stat_rd_i,
  input  logic                data_rd_i,
  input  logic                rx_done_i,
  input  logic [DATA_W-1:0]   rx_data_i,
  input  logic                rx_noise_i,
  input  logic                rx_frame_err_i,
  input  logic                idle_hit_i,
  output logic [RX_NFLAG-1:0] flags_o,
  output logic [DATA_W-1:0]   data_o
);
  logic [RX_NFLAG-1:0] flg_q, arm_q, set_v, clr_v, nxt_v;
  logic [DATA_W-1:0]   data_q;
  logic                load;

  assign load = rx_done_i && !flg_q[RX_FULL];

  always_comb begin
    set_v            = '0;
    set_v[RX_FULL]   = load;
    set_v[RX_IDLE]   = idle_hit_i;
    set_v[RX_OVR]    = rx_done_i && flg_q[RX_FULL];
    set_v[RX_NOISE]  = load && rx_noise_i;
    set_v[RX_FRAME]  = load && rx_frame_err_i;
    clr_v            = data_rd_i ? arm_q : '0;
  end

  for (genvar i = 0; i < RX_NFLAG; i++) begin : g_flag
    if (i == RX_NOISE || i == RX_FRAME) begin : g_qual
      // qualifiers follow the loaded word
      assign nxt_v[i] = load ? set_v[i] : (clr_v[i] ? 1'b0 : flg_q[i]);
    end else begin : g_evt
      assign nxt_v[i] = set_v[i] ? 1'b1 : (clr_v[i] ? 1'b0 : flg_q[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q  <= '0;
      arm_q  <= '0;
      data_q <= '0;
    end else begin
      flg_q <= nxt_v;
      if (load) data_q <= rx_data_i;
      if (stat_rd_i)      arm_q <= flg_q;
      else if (data_rd_i) arm_q <= '0;
    end
  end

  assign flags_o = flg_q;
  assign data_o  = data_q;
endmodule

// File: rtl/sci_status_ctrl.sv
module sci_status_ctrl
  import sci_status_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned IDLE_SHORT = 10,
  parameter int unsigned IDLE_LONG  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_load_i,
  input  logic              tx_busy_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_noise_i,
  input  logic              rx_frame_err_i,
  input  logic              rx_sample_i,
  input  logic              rx_line_i,
  input  logic              word_len_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  input  logic              data_wr_i,
  input  logic              tx_ie_i,
  input  logic              tc_ie_i,
  input  logic              rx_ie_i,
  input  logic              idle_ie_i,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              irq_o
);
  tx_flags_t           tx_f;
  logic [RX_NFLAG-1:0] rx_f;
  logic                idle_hit;

  sci_tx_flags u_tx (
    .clk_i, .rst_ni, .stat_rd_i, .data_wr_i, .tx_load_i, .tx_busy_i,
    .flags_o(tx_f)
  );

  sci_idle_det #(.IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG)) u_idle (
    .clk_i, .rst_ni,
    .sample_i   (rx_sample_i),
    .line_i     (rx_line_i),
    .word_len_i (word_len_i),
    .word_seen_i(rx_done_i),
    .hit_o      (idle_hit)
  );

  sci_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .stat_rd_i, .data_rd_i, .rx_done_i, .rx_data_i,
    .rx_noise_i, .rx_frame_err_i,
    .idle_hit_i(idle_hit),
    .flags_o   (rx_f),
    .data_o    (rx_data_o)
  );

  always_comb begin
    status_o          = '0;
    status_o[B_TDRE]  = tx_f.empty;
    status_o[B_TC]    = tx_f.done;
    status_o[B_RDRF]  = rx_f[RX_FULL];
    status_o[B_IDLE]  = rx_f[RX_IDLE];
    status_o[B_OVR]   = rx_f[RX_OVR];
    status_o[B_NOISE] = rx_f[RX_NOISE];
    status_o[B_FRAME] = rx_f[RX_FRAME];
  end

  assign irq_o = (tx_f.empty && tx_ie_i) || (tx_f.done && tc_ie_i) ||
                 ((rx_f[RX_FULL] || rx_f[RX_OVR]) && rx_ie_i) ||
                 (rx_f[RX_IDLE] && idle_ie_i);
endmodule

// File: rtl/sci_status_chk.sv
module sci_status_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_load_i,
  input logic              rx_done_i,
  input logic              rx_sample_i,
  input logic              rx_line_i,
  input logic              data_rd_i,
  input logic              data_wr_i,
  input logic              tx_ie_i,
  input logic              tc_ie_i,
  input logic              rx_ie_i,
  input logic              idle_ie_i,
  input logic [7:0]        status_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              irq_o
);
  a_r1_bit0_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] == 1'b0);

  a_r3_load_sets_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |=> status_o[7]);

  a_r4_empty_falls_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[7]) |-> $past(data_wr_i));

  a_r6_full_falls_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[5]) |-> $past(data_rd_i));

  a_r7_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && status_o[5]) |=> (status_o[3] && $stable(rx_data_o)));

  a_r9_idle_on_high_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[4]) |-> $past(rx_sample_i && rx_line_i));

  a_r12_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (tx_ie_i || tc_ie_i || rx_ie_i || idle_ie_i));
endmodule

bind sci_status_ctrl sci_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_load_i  (tx_load_i),
  .rx_done_i  (rx_done_i),
  .rx_sample_i(rx_sample_i),
  .rx_line_i  (rx_line_i),
  .data_rd_i  (data_rd_i),
  .data_wr_i  (data_wr_i),
  .tx_ie_i    (tx_ie_i),
  .tc_ie_i    (tc_ie_i),
  .rx_ie_i    (rx_ie_i),
  .idle_ie_i  (idle_ie_i),
  .status_o   (status_o),
  .rx_data_o  (rx_data_o),
  .irq_o      (irq_o)
);

// File: tb/sci_status_ctrl_tb.sv
`timescale 1ns/1ps
module sci_status_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_load = 0, tx_busy = 0, rx_done = 0, rx_noise = 0, rx_frame = 0;
  logic rx_sample = 0, rx_line = 1, word_len = 0;
  logic stat_rd = 0, data_rd = 0, data_wr = 0;
  logic tx_ie = 0, tc_ie = 0, rx_ie = 0, idle_ie = 0;
  logic [7:0] rx_data = 0;
  logic [7:0] status, rxd;
  logic irq;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sci_status_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_load_i(tx_load), .tx_busy_i(tx_busy),
    .rx_done_i(rx_done), .rx_data_i(rx_data), .rx_noise_i(rx_noise),
    .rx_frame_err_i(rx_frame), .rx_sample_i(rx_sample), .rx_line_i(rx_line),
    .word_len_i(word_len), .stat_rd_i(stat_rd), .data_rd_i(data_rd),
    .data_wr_i(data_wr), .tx_ie_i(tx_ie), .tc_ie_i(tc_ie), .rx_ie_i(rx_ie),
    .idle_ie_i(idle_ie), .status_o(status), .rx_data_o(rxd), .irq_o(irq)
  );

  // reference model
  bit m_te = 1, m_tc = 1, m_rf = 0, m_id = 0, m_ov = 0, m_nf = 0, m_fe = 0;
  bit a_te, a_tc, a_rf, a_id, a_ov, a_nf, a_fe;
  byte unsigned m_data = 0;
  int idle_run = 0;
  bit idle_ok = 1;

  function automatic byte unsigned m_status();
    return {m_te, m_tc, m_rf, m_id, m_ov, m_nf, m_fe, 1'b0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_te = 1; m_tc = 1; m_rf = 0; m_id = 0; m_ov = 0; m_nf = 0; m_fe = 0;
      {a_te, a_tc, a_rf, a_id, a_ov, a_nf, a_fe} = '0;
      m_data = 0; idle_run = 0; idle_ok = 1;
    end else begin
      automatic bit o_te = m_te, o_tc = m_tc, o_rf = m_rf, o_id = m_id;
      automatic bit o_ov = m_ov, o_nf = m_nf, o_fe = m_fe;
      automatic int limit = word_len ? 11 : 10;
      automatic bit hit = rx_sample && rx_line && idle_ok && (idle_run == limit - 1);
      automatic bit take = rx_done && !o_rf;
      m_te = tx_load ? 1 : (data_wr && a_te) ? 0 : o_te;
      m_tc = (data_wr && a_tc) ? 0 : (o_te && !tx_busy) ? 1 : o_tc;
      m_rf = take ? 1 : (data_rd && a_rf) ? 0 : o_rf;
      m_ov = (rx_done && o_rf) ? 1 : (data_rd && a_ov) ? 0 : o_ov;
      m_nf = take ? rx_noise : (data_rd && a_nf) ? 0 : o_nf;
      m_fe = take ? rx_frame : (data_rd && a_fe) ? 0 : o_fe;
      m_id = hit ? 1 : (data_rd && a_id) ? 0 : o_id;
      if (take) m_data = rx_data;
      if (rx_sample) idle_run = !rx_line ? 0 : (idle_run < limit ? idle_run + 1 : idle_run);
      idle_ok = rx_done ? 1 : (hit ? 0 : idle_ok);
      if (stat_rd) {a_te, a_tc, a_rf, a_id, a_ov, a_nf, a_fe} = {o_te, o_tc, o_rf, o_id, o_ov, o_nf, o_fe};
      else begin
        if (data_wr) {a_te, a_tc} = '0;
        if (data_rd) {a_rf, a_id, a_ov, a_nf, a_fe} = '0;
      end
    end
  end

  // per-clock comparison, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      automatic bit exp_irq = (m_te && tx_ie) || (m_tc && tc_ie) ||
                              ((m_rf || m_ov) && rx_ie) || (m_id && idle_ie);
      compared++;
      if (status !== m_status() || rxd !== m_data || irq !== exp_irq) begin
        mismatched++;
        $display("FAIL model R1..R12 t=%0t status=%h/%h data=%h/%h irq=%b/%b (actual/expected)",
                 $time, status, m_status(), rxd, m_data, irq, exp_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; step(); s = 0;
  endtask

  task automatic ones(input int n);
    rx_sample = 1; rx_line = 1;
    step(n);
    rx_sample = 0;
  endtask

  task automatic zero_sample();
    rx_sample = 1; rx_line = 0; step(); rx_sample = 0; rx_line = 1;
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    chk("R2 reset status", status, 8'hC0);
    chk("R2 reset data", rxd, 8'h00);
    chk("R2 reset irq", {7'd0, irq}, 8'h00);
    chk("R1 bit0", {7'd0, status[0]}, 8'h00);

    // R4: write without armed read keeps flags
    pulse(data_wr); step();
    chk("R4 write w/o status read", status, 8'hC0);

    // R4 R5: two-step clear
    pulse(stat_rd); pulse(data_wr); step();
    chk("R4 R5 tx clear sequence", status, 8'h00);

    // R3 R5: load while busy, then go idle
    tx_busy = 1;
    pulse(tx_load);
    chk("R3 empty after load", status, 8'h80);
    step();
    chk("R5 no complete while busy", {7'd0, status[6]}, 8'h00);
    tx_busy = 0; step();
    chk("R5 complete when not busy", status, 8'hC0);
    tx_ie = 1; #1;
    chk("R12 irq tx empty", {7'd0, irq}, 8'h01);
    tx_ie = 0; #1;
    chk("R12 irq masked", {7'd0, irq}, 8'h00);

    // R6 R7: receive then overrun
    rx_data = 8'hA5; pulse(rx_done);
    chk("R6 full set", status, 8'hE0);
    chk("R6 data loaded", rxd, 8'hA5);
    rx_data = 8'h3C; pulse(rx_done);
    chk("R7 overrun set", status, 8'hE8);
    chk("R7 data kept", rxd, 8'hA5);
    rx_ie = 1; #1;
    chk("R12 irq rx", {7'd0, irq}, 8'h01);
    rx_ie = 0;
    pulse(stat_rd); pulse(data_rd);
    chk("R6 R7 rx clear sequence", status, 8'hC0);

    // R8: qualifiers
    rx_data = 8'h5A; rx_noise = 1; rx_frame = 1; pulse(rx_done);
    rx_noise = 0; rx_frame = 0;
    chk("R8 noise frame set", status, 8'hE6);
    chk("R8 data", rxd, 8'h5A);
    pulse(stat_rd); pulse(data_rd);
    chk("R8 cleared", status, 8'hC0);

    // R11: flag set after status read survives data read
    pulse(stat_rd);
    rx_data = 8'h11; pulse(rx_done);
    pulse(data_rd);
    chk("R11 late flag survives", status, 8'hE0);
    pulse(stat_rd); pulse(data_rd);
    chk("R11 then clears", status, 8'hC0);

    // R9: 10-sample threshold with restart
    word_len = 0;
    ones(9);
    chk("R9 nine ones no idle", {7'd0, status[4]}, 8'h00);
    zero_sample();
    ones(9);
    chk("R9 restart after zero", {7'd0, status[4]}, 8'h00);
    ones(1);
    chk("R9 idle at ten", {7'd0, status[4]}, 8'h01);
    idle_ie = 1; #1;
    chk("R12 irq idle", {7'd0, irq}, 8'h01);
    idle_ie = 0;
    pulse(stat_rd); pulse(data_rd);
    chk("R9 idle cleared", {7'd0, status[4]}, 8'h00);

    // R10: no re-raise without a new word
    zero_sample(); ones(12);
    chk("R10 idle suppressed", {7'd0, status[4]}, 8'h00);

    // new word re-enables, 11-sample threshold
    rx_data = 8'h77; pulse(rx_done);
    pulse(stat_rd); pulse(data_rd);
    word_len = 1;
    zero_sample(); ones(10);
    chk("R9 long no idle at ten", {7'd0, status[4]}, 8'h00);
    ones(1);
    chk("R10 R9 idle at eleven", {7'd0, status[4]}, 8'h01);
    step(2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule